// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Dead Time and Phase Select

This block takes one single-ended PWM input and produces the gate commands for the two switches of a half bridge. A phase-select input chooses which switch follows the input. When `phase_sel` is high, the high-side switch is on while `pwm_in` is high. When `phase_sel` is low, the low-side switch is on while `pwm_in` is high. The other switch takes the complement. Only turn-on edges are delayed. Each transfer direction has its own programmable dead time, counted in clock cycles. A minimum on-time keeps a gate from producing a pulse shorter than the programmed length. The switches are therefore never commanded on together.

Each gate has two commands: a pull-up enable and a pull-down enable. An asserted pull-up enable drives the gate high. An asserted pull-down enable drives it low. A deasserted enable leaves that path at high impedance. The gates are held off while `drive_en_n` is high or while `uv_ok` is low.

The sequencer has five states:
- `ST_OFF`: disabled, both gates off.
- `ST_GAP_HI`: both gates off, waiting for the high side.
- `ST_ON_HI`: high side on.
- `ST_GAP_LO`: both gates off, waiting for the low side.
- `ST_ON_LO`: low side on.

Its transitions are:
- **launch**: leaves `ST_OFF` when the block is enabled. It goes to the gap state of the wanted side, or straight to that side's on state when its dead time is zero.
- **expire**: goes from a gap state to the matching on state once the dead count is served.
- **cancel**: goes from a gap state to the other side's gap or on state when the wanted side flips.
- **release**: goes from an on state to the other side's gap or on state once the on-time minimum is met.
- **kill**: goes from any state to `ST_OFF` when the block is disabled.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset until the first launch, both gates are off. Off means `hs_pd_en`=1, `ls_pd_en`=1, `hs_pu_en`=0 and `ls_pu_en`=0.
- R2: The wanted side is high when `phase_sel`=1 and `pwm_in`=1, or when `phase_sel`=0 and `pwm_in`=0. In every other case the wanted side is low.
- R3: A high-side turn-on that follows a low-side turn-off, a launch or a cancel comes after exactly `gap_to_hi` clock cycles with both gates off. When `gap_to_hi`=0, the high side turns on at the same clock edge at which the low side turns off.
- R4: A low-side turn-on that follows a high-side turn-off, a launch or a cancel comes after exactly `gap_to_lo` clock cycles with both gates off. When `gap_to_lo`=0, the transfer takes place at the same clock edge.
- R5: Turn-off is not delayed. An on gate that is no longer wanted, and whose minimum on-time is met, turns off at the first clock edge that samples the change.
- R6: While the block is enabled, a gate that has turned on stays on for at least max(`min_on_cyc`, 1) cycles.
- R7: If the wanted side flips during a gap, the pending turn-on is dropped. The new side then waits its own full dead time, counted from the edge at which the flip is sampled.
- R8: A clock edge that samples `drive_en_n`=1 or `uv_ok`=0 turns both gates off, even inside a minimum on-time. Operation resumes only at an edge that samples `drive_en_n`=0 together with `uv_ok`=1, and the wanted side then serves its dead time.
- R9: For each gate, on means pull-up enable 1 and pull-down enable 0. Off means pull-up enable 0 and pull-down enable 1.
- R10: The two pull-up enables are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Single-ended PWM command |
| phase_sel | input | 1 | 1: high side follows `pwm_in`; 0: low side follows |
| drive_en_n | input | 1 | Active-low enable; 1 forces both gates off |
| uv_ok | input | 1 | Supply good; 0 forces both gates off |
| gap_to_hi | input | CW | Dead cycles before a high-side turn-on |
| gap_to_lo | input | CW | Dead cycles before a low-side turn-on |
| min_on_cyc | input | CW | Minimum gate on-time in cycles |
| hs_pu_en | output | 1 | High-side pull-up drive (0 = high impedance) |
| hs_pd_en | output | 1 | High-side pull-down drive (0 = high impedance) |
| ls_pu_en | output | 1 | Low-side pull-up drive (0 = high impedance) |
| ls_pd_en | output | 1 | Low-side pull-down drive (0 = high impedance) |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is cancellation and dead-time expiry. The wanted side flips at the edge where the gap count is completed. The bench provokes this by toggling the input with a period close to the dead times. It judges that no gate turns on and that the new side restarts its own full count.

The second pair is disable and the minimum on-time hold. An enable or supply drop lands inside a long on-time minimum. The bench judges this against its behavioural model on every cycle: the gates must go off at once, and on return the new dead time must be served.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_GAP_HI = 3'd1,
        ST_ON_HI  = 3'd2,
        ST_GAP_LO = 3'd3,
        ST_ON_LO  = 3'd4
    } hbd_state_e;

    localparam int GATE_HI = 0;
    localparam int GATE_LO = 1;
    localparam int N_GATES = 2;

endpackage

// File: rtl/hbd_seq.sv
module hbd_seq
    import hbd_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enabled,
    input  logic          want_hi,
    input  logic [CW-1:0] gap_to_hi,
    input  logic [CW-1:0] gap_to_lo,
    input  logic [CW-1:0] min_on_cyc,
    output logic          hi_on,
    output logic          lo_on
);

    localparam int LW = CW + 1;

    hbd_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // destination for a transfer towards one side
    function automatic hbd_state_e launch_to(input logic to_hi,
                                             input logic [CW-1:0] g_hi,
                                             input logic [CW-1:0] g_lo);
        if (to_hi) return (g_hi == '0) ? ST_ON_HI : ST_GAP_HI;
        else       return (g_lo == '0) ? ST_ON_LO : ST_GAP_LO;
    endfunction

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!enabled) begin
            state_d = ST_OFF;               // kill
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin                // launch
                    state_d = launch_to(want_hi, gap_to_hi, gap_to_lo);
                    cnt_d   = CW'(1);
                end
                ST_GAP_HI: begin
                    if (!want_hi) begin      // cancel
                        state_d = launch_to(1'b0, gap_to_hi, gap_to_lo);
                        cnt_d   = CW'(1);
                    end else if (cnt_q >= gap_to_hi) begin // expire
                        state_d = ST_ON_HI;
                        cnt_d   = CW'(1);
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_GAP_LO: begin
                    if (want_hi) begin       // cancel
                        state_d = launch_to(1'b1, gap_to_hi, gap_to_lo);
                        cnt_d   = CW'(1);
                    end else if (cnt_q >= gap_to_lo) begin // expire
                        state_d = ST_ON_LO;
                        cnt_d   = CW'(1);
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_ON_HI: begin
                    if (!want_hi && cnt_q >= min_on_cyc) begin // release
                        state_d = launch_to(1'b0, gap_to_hi, gap_to_lo);
                        cnt_d   = CW'(1);
                    end else if (cnt_q < min_on_cyc) begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_ON_LO: begin
                    if (want_hi && cnt_q >= min_on_cyc) begin  // release
                        state_d = launch_to(1'b1, gap_to_hi, gap_to_lo);
                        cnt_d   = CW'(1);
                    end else if (cnt_q < min_on_cyc) begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                default: begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        hi_on = 1'b0;
        lo_on = 1'b0;
        unique case (state_q)
            ST_ON_HI: hi_on = 1'b1;
            ST_ON_LO: lo_on = 1'b1;
            default: begin
                hi_on = 1'b0;
                lo_on = 1'b0;
            end
        endcase
    end

    // ---------------- checking logic ----------------
    logic [LW-1:0] hi_len_q, lo_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len_q <= '0;
            lo_len_q <= '0;
        end else begin
            hi_len_q <= !hi_on ? '0 : ((&hi_len_q) ? hi_len_q : hi_len_q + LW'(1));
            lo_len_q <= !lo_on ? '0 : ((&lo_len_q) ? lo_len_q : lo_len_q + LW'(1));
        end
    end

    a_r6_hi_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_on && enabled && (int'(hi_len_q) + 1 < int'(min_on_cyc))) |=> hi_on);

    a_r6_lo_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_on && enabled && (int'(lo_len_q) + 1 < int'(min_on_cyc))) |=> lo_on);

    a_r5_hi_prompt_off: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_on && enabled && !want_hi && (int'(hi_len_q) + 1 >= int'(min_on_cyc))) |=> !hi_on);

    a_r5_lo_prompt_off: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_on && enabled && want_hi && (int'(lo_len_q) + 1 >= int'(min_on_cyc))) |=> !lo_on);

    a_r3_gap_before_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_on && gap_to_hi != '0) |=> !hi_on);

    a_r4_gap_before_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_on && gap_to_lo != '0) |=> !lo_on);

    a_r8_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> (!hi_on && !lo_on));

endmodule

// File: rtl/hbd_gate_drv.sv
module hbd_gate_drv (
    input  logic gate_on,
    output logic pu_en,
    output logic pd_en
);

    // one path of the pair drives, the other floats
    always_comb begin
        if (gate_on) begin
            pu_en = 1'b1;
            pd_en = 1'b0;
        end else begin
            pu_en = 1'b0;
            pd_en = 1'b1;
        end
    end

endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
    import hbd_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm_in,
    input  logic          phase_sel,
    input  logic          drive_en_n,
    input  logic          uv_ok,
    input  logic [CW-1:0] gap_to_hi,
    input  logic [CW-1:0] gap_to_lo,
    input  logic [CW-1:0] min_on_cyc,
    output logic          hs_pu_en,
    output logic          hs_pd_en,
    output logic          ls_pu_en,
    output logic          ls_pd_en
);

    logic               enabled;
    logic               want_hi;
    logic [N_GATES-1:0] gate_on;
    logic [N_GATES-1:0] pu_vec;
    logic [N_GATES-1:0] pd_vec;

    assign enabled = !drive_en_n && uv_ok;
    assign want_hi = phase_sel ? pwm_in : !pwm_in;

    hbd_seq #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enabled    (enabled),
        .want_hi    (want_hi),
        .gap_to_hi  (gap_to_hi),
        .gap_to_lo  (gap_to_lo),
        .min_on_cyc (min_on_cyc),
        .hi_on      (gate_on[GATE_HI]),
        .lo_on      (gate_on[GATE_LO])
    );

    for (genvar g = 0; g < N_GATES; g++) begin : g_drv
        hbd_gate_drv u_drv (
            .gate_on (gate_on[g]),
            .pu_en   (pu_vec[g]),
            .pd_en   (pd_vec[g])
        );
    end

    assign hs_pu_en = pu_vec[GATE_HI];
    assign hs_pd_en = pd_vec[GATE_HI];
    assign ls_pu_en = pu_vec[GATE_LO];
    assign ls_pd_en = pd_vec[GATE_LO];

    a_r10_pullups_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_pu_en && ls_pu_en));

    a_r1_reset_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (hs_pd_en && ls_pd_en && !hs_pu_en && !ls_pu_en));

endmodule

// File: tb/hb_deadtime_ctrl_tb.sv
module hb_deadtime_ctrl_tb;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwm_in = 1'b0;
    logic          phase_sel = 1'b0;
    logic          drive_en_n = 1'b1;
    logic          uv_ok = 1'b0;
    logic [CW-1:0] gap_to_hi = '0;
    logic [CW-1:0] gap_to_lo = '0;
    logic [CW-1:0] min_on_cyc = '0;
    logic          hs_pu_en, hs_pd_en, ls_pu_en, ls_pd_en;

    int    n_checks = 0;
    int    n_fails  = 0;
    string tag = "R1";
    bit    run = 1'b0;
    bit    done = 1'b0;

    // behavioural model: 0 none, 1 high side, 2 low side
    int m_cur = 0, m_pend = 0, m_rem = 0, m_ton = 0;

    always #2 clk = ~clk;   // 250 MHz

    hb_deadtime_ctrl #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .phase_sel(phase_sel),
        .drive_en_n(drive_en_n), .uv_ok(uv_ok), .gap_to_hi(gap_to_hi),
        .gap_to_lo(gap_to_lo), .min_on_cyc(min_on_cyc),
        .hs_pu_en(hs_pu_en), .hs_pd_en(hs_pd_en),
        .ls_pu_en(ls_pu_en), .ls_pd_en(ls_pd_en)
    );

    function automatic int gap_of(int side);
        return (side == 1) ? int'(gap_to_hi) : int'(gap_to_lo);
    endfunction

    task automatic start_side(int side);
        m_cur  = 0;
        m_pend = side;
        m_rem  = gap_of(side);
        if (m_rem == 0) begin
            m_cur  = side;
            m_ton  = 0;
            m_pend = 0;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || drive_en_n || !uv_ok) begin
            m_cur  = 0;
            m_pend = 0;
        end else begin
            int want;
            want = ((phase_sel && pwm_in) || (!phase_sel && !pwm_in)) ? 1 : 2;
            if (m_cur == 0) begin
                if (m_pend != want) start_side(want);
                else begin
                    m_rem = m_rem - 1;
                    if (m_rem <= 0) begin
                        m_cur  = want;
                        m_ton  = 0;
                        m_pend = 0;
                    end
                end
            end else begin
                m_ton = m_ton + 1;
                if (want != m_cur && m_ton >= int'(min_on_cyc)) start_side(want);
            end
        end
    end

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s at %0t: outputs {hs_pu,hs_pd,ls_pu,ls_pd}=%b expected %b",
                     req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (run && !done) begin
            logic [3:0] exp;
            exp = {m_cur == 1, m_cur != 1, m_cur == 2, m_cur != 2};
            check({tag, "/R9"}, {hs_pu_en, hs_pd_en, ls_pu_en, ls_pd_en}, exp);
            n_checks++;
            if (hs_pu_en && ls_pu_en) begin
                n_fails++;
                $display("FAIL R10 at %0t: both pull-ups act=11 expected not 11", $time);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(int ghi, int glo, int mn);
        drive_en_n = 1'b1;
        cyc(2);
        gap_to_hi  = CW'(ghi);
        gap_to_lo  = CW'(glo);
        min_on_cyc = CW'(mn);
        drive_en_n = 1'b0;
    endtask

    task automatic pulses(int hi_len, int lo_len, int reps);
        for (int i = 0; i < reps; i++) begin
            pwm_in = 1'b1; cyc(hi_len);
            pwm_in = 1'b0; cyc(lo_len);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // R1: reset state
        cyc(2);
        run = 1'b1;
        check("R1", {hs_pu_en, hs_pd_en, ls_pu_en, ls_pd_en}, 4'b0101);
        cyc(1);
        rst_n = 1'b1;
        uv_ok = 1'b1;
        cyc(3);
        check("R1", {hs_pu_en, hs_pd_en, ls_pu_en, ls_pd_en}, 4'b0101);

        // R2: phase selection, both polarities
        tag = "R2";
        phase_sel = 1'b1;
        cfg(3, 2, 0);
        pulses(10, 10, 3);
        pulses(6, 8, 2);
        phase_sel = 1'b0;
        pulses(9, 7, 3);

        // R3: high-side dead time, zero and non-zero
        tag = "R3";
        phase_sel = 1'b1;
        cfg(0, 4, 0);
        pulses(8, 9, 3);
        cfg(7, 1, 0);
        pulses(12, 12, 2);

        // R4: low-side dead time
        tag = "R4";
        cfg(5, 0, 0);
        pulses(9, 9, 3);
        cfg(2, 9, 0);
        pulses(14, 14, 2);

        // R5: prompt turn-off with fast toggles
        tag = "R5";
        cfg(1, 1, 0);
        pulses(2, 2, 6);
        pulses(3, 1, 4);

        // R6: minimum on-time stretches short requests
        tag = "R6";
        cfg(2, 2, 6);
        pulses(4, 1, 4);
        pulses(1, 12, 3);
        cfg(0, 0, 3);
        pulses(1, 1, 6);

        // R7: flips during gaps cancel pending turn-ons
        tag = "R7";
        cfg(6, 6, 0);
        pulses(3, 3, 5);
        pulses(6, 6, 3);
        pulses(5, 7, 3);

        // R8: disable and supply drop override minimum on-time
        tag = "R8";
        cfg(3, 3, 10);
        pwm_in = 1'b1; cyc(6);
        drive_en_n = 1'b1; cyc(3);
        drive_en_n = 1'b0; cyc(8);
        uv_ok = 1'b0; cyc(2);
        pwm_in = 1'b0; cyc(2);
        uv_ok = 1'b1; cyc(4);
        drive_en_n = 1'b1; uv_ok = 1'b0; cyc(2);
        uv_ok = 1'b1; cyc(2);
        check("R8", {hs_pu_en, hs_pd_en, ls_pu_en, ls_pd_en}, 4'b0101);
        drive_en_n = 1'b0; cyc(20);

        // R10: pseudo-random activity
        tag = "R10";
        cfg(2, 3, 2);
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) pwm_in = ~pwm_in;
            if (lfsr[9:4] == 6'd5) phase_sel = ~phase_sel;
            uv_ok = (lfsr[15:9] != 7'd3);
            cyc(1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule